// File: doc/BRIEF.md
# Region-Based Memory Write Guard

This block sits between a multithreaded pipeline and its data memory and decides, every cycle, whether a store may proceed. Loads are never routed through it. A store is allowed when its address falls in a shared window that always begins at address zero, or in a private window that belongs to the thread issuing the store. Every other store has its enable forced low in the same cycle, and a violation pulse naming the offending thread follows one cycle later.

Window limits are held in bound registers counted in 1 KiB pages. One register gives the top of the shared window. Each thread has two registers, giving the bottom and the top of its private window. The registers are loaded through a configuration port, and a load takes effect only when the port's supervisor flag is set. A load attempted without that flag changes nothing and is reported as a violation. After reset every limit is zero, so all stores are refused until supervisory software has opened some windows.

The violation reporter is a two-state machine. QUIET means no pulse is being driven. RAISED drives `viol_o` and holds the thread ID that caused it. The machine moves from QUIET to RAISED on any offence. It stays in RAISED when a new offence arrives in the very next cycle, and it returns to QUIET in the first cycle that has no offence.

Top module: `spatial_write_guard`

## Requirements
- R1: After reset, the shared top and every private bottom and top bound are zero, so every store is refused until the bounds are configured.
- R2: Any thread may store to an address whose page number (address bits 10 and up) is below the shared top bound.
- R3: A thread may store to a page inside its own private window. The same page is refused to a thread that has no other permission for it.
- R4: Only address bits 10 and up are compared. Two addresses in the same 1 KiB page always receive the same verdict. Addresses 0x07FF and 0x0800 lie in different pages.
- R5: The bottom bound is inclusive and the top bound is exclusive. A window whose bottom is equal to or above its top is empty. A top bound of 64 (with 16-bit addresses) reaches the last page.
- R6: A refused store drives `wr_en_o` low in the same cycle. In the next cycle `viol_o` is high for exactly one cycle, and `viol_tid_o` carries the store's thread ID.
- R7: An allowed store drives `wr_en_o` high in the same cycle, and no violation follows.
- R8: A configuration write with `cfg_super_i` high updates its register at the clock edge, and the new bound applies from the next cycle. The `cfg_sel_i` encoding is: 0 for the shared top, 1 for the private bottom of thread `cfg_tid_i`, 2 for the private top of thread `cfg_tid_i`, and 3 for no register.
- R9: A configuration write with `cfg_super_i` low leaves every bound unchanged. It raises `viol_o` in the next cycle, with `viol_tid_o` equal to `cfg_src_tid_i`.
- R10: When a refused store and a non-supervisory configuration write happen in the same cycle, `viol_tid_o` reports the store's thread.
- R11: With `wr_en_i` low, `wr_en_o` stays low and no violation is raised, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Store request from the pipeline |
| wr_addr_i | input | ADDR_W (16) | Store byte address |
| wr_tid_i | input | TID_W (2) | Thread issuing the store |
| wr_en_o | output | 1 | Store enable passed to the memory |
| cfg_en_i | input | 1 | Bound register write strobe |
| cfg_super_i | input | 1 | Writer is in supervisory mode |
| cfg_src_tid_i | input | TID_W (2) | Thread issuing the configuration write |
| cfg_sel_i | input | 2 | Register select (0 shared top, 1 private bottom, 2 private top, 3 none) |
| cfg_tid_i | input | TID_W (2) | Thread whose private bound is written |
| cfg_val_i | input | BOUND_W (7) | New bound in pages |
| viol_o | output | 1 | One-cycle violation pulse |
| viol_tid_o | output | TID_W (2) | Thread that caused the violation |

## Verification
The hardest case to reach from the ports is the cycle in which a refused store and an unprivileged configuration write arrive together. Both offences compete for the single report, and the configuration write must still be dropped. The bench drives both in one cycle with different thread IDs. It checks which ID is reported, and then issues a store that would only succeed if the dropped write had opened the whole memory. The upper edge of the address space is also reached on purpose: a thread's window top is set to the out-of-range page value 64, so that the last page is covered.

// File: rtl/guard_pkg.sv
package guard_pkg;

    // Register select on the configuration port
    typedef enum logic [1:0] {
        SEL_SHARED_TOP = 2'd0,
        SEL_PRIV_LO    = 2'd1,
        SEL_PRIV_HI    = 2'd2,
        SEL_NONE       = 2'd3
    } cfg_sel_e;

    // Violation reporter states
    typedef enum logic {
        ALM_QUIET  = 1'b0,
        ALM_RAISED = 1'b1
    } alarm_state_e;

endpackage

// File: rtl/guard_bounds.sv
module guard_bounds
    import guard_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int TID_W       = 2,
    parameter int BOUND_W     = 7
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  cfg_en_i,
    input  logic                                  cfg_super_i,
    input  logic [1:0]                            cfg_sel_i,
    input  logic [TID_W-1:0]                      cfg_tid_i,
    input  logic [BOUND_W-1:0]                    cfg_val_i,
    output logic [BOUND_W-1:0]                    shr_top_o,
    output logic [NUM_THREADS-1:0][BOUND_W-1:0]   lo_o,
    output logic [NUM_THREADS-1:0][BOUND_W-1:0]   hi_o
);

    logic     apply;
    cfg_sel_e sel;

    assign apply = cfg_en_i && cfg_super_i;
    assign sel   = cfg_sel_e'(cfg_sel_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shr_top_o <= '0;
        end else if (apply && sel == SEL_SHARED_TOP) begin
            shr_top_o <= cfg_val_i;
        end
    end

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        logic hit_thr;
        assign hit_thr = apply && (int'(cfg_tid_i) == t);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_o[t] <= '0;
                hi_o[t] <= '0;
            end else if (hit_thr) begin
                if (sel == SEL_PRIV_LO) lo_o[t] <= cfg_val_i;
                if (sel == SEL_PRIV_HI) hi_o[t] <= cfg_val_i;
            end
        end
    end

endmodule

// File: rtl/guard_region_check.sv
module guard_region_check #(
    parameter int NUM_THREADS = 4,
    parameter int TID_W       = 2,
    parameter int PAGE_W      = 6,
    parameter int BOUND_W     = 7
) (
    input  logic [PAGE_W-1:0]                     page_i,
    input  logic [TID_W-1:0]                      tid_i,
    input  logic [BOUND_W-1:0]                    shr_top_i,
    input  logic [NUM_THREADS-1:0][BOUND_W-1:0]   lo_i,
    input  logic [NUM_THREADS-1:0][BOUND_W-1:0]   hi_i,
    output logic                                  allow_o
);

    logic [BOUND_W-1:0]     page_ext;
    logic [NUM_THREADS-1:0] in_priv;
    logic                   in_shared;
    logic                   own_hit;

    assign page_ext  = BOUND_W'(page_i);
    assign in_shared = page_ext < shr_top_i;

    // Window match per thread: bottom inclusive, top exclusive
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_win
        assign in_priv[t] = (page_ext >= lo_i[t]) && (page_ext < hi_i[t]);
    end

    always_comb begin
        own_hit = 1'b0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            if (int'(tid_i) == t) own_hit = in_priv[t];
        end
    end

    assign allow_o = in_shared || own_hit;

endmodule

// File: rtl/guard_alarm.sv
module guard_alarm
    import guard_pkg::*;
#(
    parameter int TID_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             deny_i,
    input  logic [TID_W-1:0] deny_tid_i,
    input  logic             cfg_bad_i,
    input  logic [TID_W-1:0] cfg_tid_i,
    output logic             viol_o,
    output logic [TID_W-1:0] viol_tid_o
);

    alarm_state_e state_q, state_d;
    logic         offence;

    assign offence = deny_i || cfg_bad_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ALM_QUIET:  if (offence)  state_d = ALM_RAISED;
            ALM_RAISED: if (!offence) state_d = ALM_QUIET;
            default:    state_d = ALM_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ALM_QUIET;
        else        state_q <= state_d;
    end

    // Culprit register: a refused store outranks a bad configuration write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            viol_tid_o <= '0;
        end else if (deny_i) begin
            viol_tid_o <= deny_tid_i;
        end else if (cfg_bad_i) begin
            viol_tid_o <= cfg_tid_i;
        end
    end

    assign viol_o = (state_q == ALM_RAISED);

endmodule

// File: rtl/spatial_write_guard.sv
module spatial_write_guard #(
    parameter int ADDR_W      = 16,
    parameter int NUM_THREADS = 4,
    parameter int PAGE_LOG2   = 10,
    parameter int TID_W       = $clog2(NUM_THREADS),
    parameter int PAGE_W      = ADDR_W - PAGE_LOG2,
    parameter int BOUND_W     = PAGE_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [TID_W-1:0]   wr_tid_i,
    output logic               wr_en_o,
    input  logic               cfg_en_i,
    input  logic               cfg_super_i,
    input  logic [TID_W-1:0]   cfg_src_tid_i,
    input  logic [1:0]         cfg_sel_i,
    input  logic [TID_W-1:0]   cfg_tid_i,
    input  logic [BOUND_W-1:0] cfg_val_i,
    output logic               viol_o,
    output logic [TID_W-1:0]   viol_tid_o
);

    logic [BOUND_W-1:0]                   shr_top;
    logic [NUM_THREADS-1:0][BOUND_W-1:0]  lo_b;
    logic [NUM_THREADS-1:0][BOUND_W-1:0]  hi_b;
    logic                                 allow;
    logic                                 deny;
    logic                                 cfg_bad;
    logic                                 unused_offset;

    // Byte offset within a page plays no part in the verdict
    assign unused_offset = ^wr_addr_i[PAGE_LOG2-1:0];

    guard_bounds #(
        .NUM_THREADS (NUM_THREADS),
        .TID_W       (TID_W),
        .BOUND_W     (BOUND_W)
    ) i_bounds (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_en_i    (cfg_en_i),
        .cfg_super_i (cfg_super_i),
        .cfg_sel_i   (cfg_sel_i),
        .cfg_tid_i   (cfg_tid_i),
        .cfg_val_i   (cfg_val_i),
        .shr_top_o   (shr_top),
        .lo_o        (lo_b),
        .hi_o        (hi_b)
    );

    guard_region_check #(
        .NUM_THREADS (NUM_THREADS),
        .TID_W       (TID_W),
        .PAGE_W      (PAGE_W),
        .BOUND_W     (BOUND_W)
    ) i_check (
        .page_i      (wr_addr_i[ADDR_W-1:PAGE_LOG2]),
        .tid_i       (wr_tid_i),
        .shr_top_i   (shr_top),
        .lo_i        (lo_b),
        .hi_i        (hi_b),
        .allow_o     (allow)
    );

    assign wr_en_o = wr_en_i && allow;
    assign deny    = wr_en_i && !allow;
    assign cfg_bad = cfg_en_i && !cfg_super_i;

    guard_alarm #(
        .TID_W (TID_W)
    ) i_alarm (
        .clk        (clk),
        .rst_n      (rst_n),
        .deny_i     (deny),
        .deny_tid_i (wr_tid_i),
        .cfg_bad_i  (cfg_bad),
        .cfg_tid_i  (cfg_src_tid_i),
        .viol_o     (viol_o),
        .viol_tid_o (viol_tid_o)
    );

endmodule

// File: rtl/guard_checker.sv
module guard_checker #(
    parameter int TID_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en_i,
    input logic [TID_W-1:0] wr_tid_i,
    input logic             wr_en_o,
    input logic             cfg_en_i,
    input logic             cfg_super_i,
    input logic [TID_W-1:0] cfg_src_tid_i,
    input logic             viol_o,
    input logic [TID_W-1:0] viol_tid_o
);

    AST_GATE_ONLY_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> wr_en_i); // R6

    AST_DENY_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_en_o) |=> (viol_o && viol_tid_o == $past(wr_tid_i))); // R6

    AST_CFG_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en_i && !cfg_super_i && !wr_en_i) |=> (viol_o && viol_tid_o == $past(cfg_src_tid_i))); // R9

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en_i && !wr_en_o) && !(cfg_en_i && !cfg_super_i)) |=> !viol_o); // R7

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |-> !wr_en_o); // R11

endmodule

bind spatial_write_guard guard_checker #(.TID_W(TID_W)) i_guard_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en_i       (wr_en_i),
    .wr_tid_i      (wr_tid_i),
    .wr_en_o       (wr_en_o),
    .cfg_en_i      (cfg_en_i),
    .cfg_super_i   (cfg_super_i),
    .cfg_src_tid_i (cfg_src_tid_i),
    .viol_o        (viol_o),
    .viol_tid_o    (viol_tid_o)
);

// File: tb/test_spatial_write_guard.sv
module test_spatial_write_guard;

    localparam int ADDR_W  = 16;
    localparam int TID_W   = 2;
    localparam int BOUND_W = 7;
    localparam int NVEC    = 12;

    // {addr[15:0], tid[7:0], expect_allow[7:0]}
    localparam bit [31:0] VEC [NVEC] = '{
        {16'h0000, 8'd2, 8'd1},  // R2 shared page 0
        {16'h07FF, 8'd3, 8'd1},  // R4 last byte of shared page 1
        {16'h0800, 8'd0, 8'd0},  // R4 first byte of page 2
        {16'h1000, 8'd0, 8'd1},  // R5 bottom inclusive
        {16'h17FF, 8'd0, 8'd1},  // R3 own window
        {16'h1800, 8'd0, 8'd0},  // R5 top exclusive
        {16'h1800, 8'd1, 8'd1},  // R3 thread 1 window
        {16'h1000, 8'd1, 8'd0},  // R3 foreign window
        {16'h1400, 8'd2, 8'd0},  // R5 empty window
        {16'hF000, 8'd3, 8'd1},  // R5 page 60
        {16'hFFFF, 8'd3, 8'd1},  // R5 last page via top 64
        {16'hFFFF, 8'd0, 8'd0}   // R3 last page foreign
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en_i = 1'b0;
    logic [ADDR_W-1:0]  wr_addr_i = '0;
    logic [TID_W-1:0]   wr_tid_i = '0;
    logic               wr_en_o;
    logic               cfg_en_i = 1'b0;
    logic               cfg_super_i = 1'b0;
    logic [TID_W-1:0]   cfg_src_tid_i = '0;
    logic [1:0]         cfg_sel_i = '0;
    logic [TID_W-1:0]   cfg_tid_i = '0;
    logic [BOUND_W-1:0] cfg_val_i = '0;
    logic               viol_o;
    logic [TID_W-1:0]   viol_tid_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spatial_write_guard i_spatial_write_guard (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (wr_en_i),
        .wr_addr_i     (wr_addr_i),
        .wr_tid_i      (wr_tid_i),
        .wr_en_o       (wr_en_o),
        .cfg_en_i      (cfg_en_i),
        .cfg_super_i   (cfg_super_i),
        .cfg_src_tid_i (cfg_src_tid_i),
        .cfg_sel_i     (cfg_sel_i),
        .cfg_tid_i     (cfg_tid_i),
        .cfg_val_i     (cfg_val_i),
        .viol_o        (viol_o),
        .viol_tid_o    (viol_tid_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Store: enable checked in the same cycle, report in the next
    task automatic do_store(input logic [15:0] addr, input int tid, input bit allow, input string req);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = addr; wr_tid_i = TID_W'(tid);
        #2;
        chk(wr_en_o == allow, req, int'(wr_en_o), int'(allow));
        @(negedge clk);
        wr_en_i = 1'b0;
        #1;
        chk(viol_o == !allow, req, int'(viol_o), int'(!allow));
        if (!allow) chk(int'(viol_tid_o) == tid, req, int'(viol_tid_o), tid);
    endtask

    task automatic do_cfg(input bit sup, input int src, input int sel, input int tid, input int val);
        @(negedge clk);
        cfg_en_i = 1'b1; cfg_super_i = sup; cfg_src_tid_i = TID_W'(src);
        cfg_sel_i = 2'(sel); cfg_tid_i = TID_W'(tid); cfg_val_i = BOUND_W'(val);
        @(negedge clk);
        cfg_en_i = 1'b0; cfg_super_i = 1'b0;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 5000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state at the ports
        chk(viol_o == 1'b0, "R1", int'(viol_o), 0);
        chk(wr_en_o == 1'b0, "R1", int'(wr_en_o), 0);
        do_store(16'h0000, 0, 1'b0, "R1");
        do_store(16'hFFFF, 3, 1'b0, "R1");

        // R9: unprivileged write is dropped but reported
        do_cfg(1'b0, 1, 0, 0, 64);
        chk(viol_o == 1'b1, "R9", int'(viol_o), 1);
        chk(viol_tid_o == 2'd1, "R9", int'(viol_tid_o), 1);
        do_store(16'h2000, 1, 1'b0, "R9");

        // R8: supervisor configuration, applies from the next cycle
        do_cfg(1'b1, 0, 0, 0, 2);
        chk(viol_o == 1'b0, "R8", int'(viol_o), 0);
        do_store(16'h0400, 0, 1'b1, "R8");
        do_cfg(1'b1, 0, 1, 0, 4);
        do_cfg(1'b1, 0, 2, 0, 6);
        do_cfg(1'b1, 0, 1, 1, 6);
        do_cfg(1'b1, 0, 2, 1, 8);
        do_cfg(1'b1, 0, 1, 2, 5);
        do_cfg(1'b1, 0, 2, 2, 5);
        do_cfg(1'b1, 0, 1, 3, 60);
        do_cfg(1'b1, 0, 2, 3, 64);
        do_cfg(1'b1, 0, 3, 0, 0);  // R8 select 3 touches nothing
        do_store(16'h0400, 1, 1'b1, "R8");

        for (int i = 0; i < NVEC; i++) begin
            do_store(VEC[i][31:16], int'(VEC[i][15:8]), VEC[i][0], $sformatf("R2/R3/R4/R5 vec%0d", i));
        end

        // R10: refused store and bad configuration in the same cycle
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = 16'h0800; wr_tid_i = 2'd2;
        cfg_en_i = 1'b1; cfg_super_i = 1'b0; cfg_src_tid_i = 2'd3;
        cfg_sel_i = 2'd0; cfg_val_i = 7'd64;
        #2;
        chk(wr_en_o == 1'b0, "R10", int'(wr_en_o), 0);
        @(negedge clk);
        wr_en_i = 1'b0; cfg_en_i = 1'b0;
        #1;
        chk(viol_o == 1'b1, "R10", int'(viol_o), 1);
        chk(viol_tid_o == 2'd2, "R10", int'(viol_tid_o), 2);
        do_store(16'h0800, 2, 1'b0, "R10");

        // R11: idle cycle with a refused address
        @(negedge clk);
        wr_en_i = 1'b0; wr_addr_i = 16'h3000; wr_tid_i = 2'd1;
        #2;
        chk(wr_en_o == 1'b0, "R11", int'(wr_en_o), 0);
        @(negedge clk);
        #1;
        chk(viol_o == 1'b0, "R11", int'(viol_o), 0);

        // R8: live change opens the empty window of thread 2
        do_cfg(1'b1, 0, 2, 2, 6);
        do_store(16'h1400, 2, 1'b1, "R8");
        do_store(16'h1800, 2, 1'b0, "R8");

        finish_run();
    end

endmodule